// File: doc/BRIEF.md
# Automatic Level Controller

This block keeps a two-channel stream of signed PCM samples inside a level band. Each channel watches the magnitude of its own samples and steers an unsigned gain code that a downstream volume stage applies. One code is 0.5 dB, and a larger code means more gain. When the loudest sample of a window reaches the upper level, the gain is pulled down (attack). When the loudest sample of a window stays under the lower level, the gain is pushed up (release). Between the two levels the gain rests, so the lower level acts as a hysteresis point.

Attack and release run on separate sample windows. Each window's length comes from its own 6-bit rate code. The gain target moves in steps of `ALC_STEP` codes. The output gain code then either ramps toward that target one code per sample, or jumps to it in a single step when the instant bit is set. A channel whose loop is switched off outputs its programmed manual code. A single-volume mode makes channel A's enable govern channel B as well.

Top module: `alc_ctrl`

## Requirements
- R1: While `rst_n` is low, both gain outputs equal the parameter `GAIN_RESET`.
- R2: While a channel's effective enable is low, its gain output equals its manual code clamped to [`GAIN_FLOOR`, `GAIN_CEIL`], one clock after the manual value is applied, whether or not samples arrive.
- R3: Level thresholds use code k (0..7) with FS = 2^(SMP_W-1): T(k) = FS >> (k/2), and for odd k that value is then multiplied by 181 and shifted right by 8. A window whose peak |x| is >= T(max code) attacks. Otherwise a window whose peak is < T(min code) releases. Otherwise the target is unchanged. Attack wins when both fire on the same sample, and |-FS| counts as FS.
- R4: The attack decision falls on every (ARATE+1)*BASE_IVL-th valid sample after enable or after the previous attack decision, and lowers the target by `ALC_STEP` codes.
- R5: The release decision falls on every (RRATE+1)*BASE_IVL-th valid sample, counted the same way on its own counter, and raises the target by `ALC_STEP` codes.
- R6: The target and the gain output never leave [`GAIN_FLOOR`, `GAIN_CEIL`]. A step past a limit stops at the limit.
- R7: With the instant bit clear, the gain output moves one code toward the target on each valid sample of its channel, beginning on the decision sample. Without a valid sample it does not change.
- R8: With the instant bit set, the gain output takes the new target on the same clock edge as the decision sample.
- R9: With `cfg_single` set, channel B's loop is enabled by `cfg_en_a`, and `cfg_en_b` has no effect.
- R10: Samples of one channel never change the other channel's gain.
- R11: Each window's peak covers only the samples of that window, including the deciding sample, and it restarts empty after every decision of that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_a | input | 1 | Loop enable, channel A |
| cfg_en_b | input | 1 | Loop enable, channel B (ignored in single mode) |
| cfg_single | input | 1 | Channel A's enable governs both channels |
| cfg_instant | input | 1 | Gain output jumps to the target instead of ramping |
| cfg_max_lvl | input | 3 | Upper level code (attack threshold) |
| cfg_min_lvl | input | 3 | Lower level code (release threshold) |
| cfg_atk_rate | input | 6 | Attack rate code, 0 fastest |
| cfg_rel_rate | input | 6 | Release rate code, 0 fastest |
| cfg_manual_a | input | GAIN_W | Manual gain code, channel A |
| cfg_manual_b | input | GAIN_W | Manual gain code, channel B |
| smp_vld_a | input | 1 | Sample strobe, channel A |
| smp_a | input | SMP_W | Signed sample, channel A |
| smp_vld_b | input | 1 | Sample strobe, channel B |
| smp_b | input | SMP_W | Signed sample, channel B |
| gain_a | output | GAIN_W | Gain code, channel A |
| gain_b | output | GAIN_W | Gain code, channel B |

## Verification
The bench builds the block with 8-bit samples, a 5-bit gain code limited to 2..20, a base interval of one sample and a step of two codes. Every level threshold is then a small integer, and all 64 pairings of upper and lower codes can be swept at both edges of each threshold, with both signs of sample, including the most negative value. The one-sample base interval keeps the longest window at 64 samples, so every attack and release rate code is walked through, and the window ends exactly where the formula puts it.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int RATE_W   = 6;
  localparam int RATE_N   = 1 << RATE_W;
  localparam int LVL_W    = 3;
  localparam int LVL_N    = 1 << LVL_W;
  localparam int RT2_MUL  = 181;
  localparam int RT2_SHR  = 8;

  // Threshold for level code k: full scale lowered by 3 dB per code.
  function automatic longint unsigned lvl_thresh(int smp_w, int k);
    longint unsigned t;
    t = (64'd1 << (smp_w - 1)) >> (k / 2);
    if ((k % 2) == 1) t = (t * RT2_MUL) >> RT2_SHR;
    return t;
  endfunction

  function automatic int clamp_int(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/alc_thresh_dec.sv
module alc_thresh_dec
  import alc_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input  logic [LVL_W-1:0] lvl,
  output logic [SMP_W-1:0] thr
);
  logic [SMP_W-1:0] tbl [LVL_N];

  for (genvar g = 0; g < LVL_N; g++) begin : g_tbl
    localparam longint unsigned TVAL = lvl_thresh(SMP_W, g);
    assign tbl[g] = SMP_W'(TVAL);
  end

  assign thr = tbl[lvl];
endmodule

// File: rtl/alc_window.sv
module alc_window
  import alc_pkg::*;
#(
  parameter int SMP_W    = 24,
  parameter int BASE_IVL = 4,
  localparam int CNT_W   = $clog2(RATE_N * BASE_IVL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              vld,
  input  logic [SMP_W-1:0]  mag,
  input  logic [RATE_W-1:0] rate,
  output logic              fire,
  output logic [SMP_W-1:0]  peak
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic [SMP_W-1:0] pk_q, pk_d;
  logic             upd;

  always_comb begin
    lim  = CNT_W'((int'(rate) + 1) * BASE_IVL - 1);
    peak = (mag > pk_q) ? mag : pk_q;
    fire = vld && (cnt_q >= lim);
    upd  = clr || vld;
    cnt_d = cnt_q;
    pk_d  = pk_q;
    if (clr || fire) begin
      cnt_d = '0;
      pk_d  = '0;
    end else if (vld) begin
      cnt_d = cnt_q + CNT_W'(1);
      pk_d  = peak;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pk_q  <= '0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      pk_q  <= pk_d;
    end
  end
endmodule

// File: rtl/alc_gain_track.sv
module alc_gain_track
  import alc_pkg::*;
#(
  parameter int GAIN_W     = 6,
  parameter int GAIN_FLOOR = 0,
  parameter int GAIN_CEIL  = 40,
  parameter int GAIN_RESET = 24,
  parameter int ALC_STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              vld,
  input  logic              atk,
  input  logic              rel,
  input  logic              instant,
  input  logic [GAIN_W-1:0] manual,
  output logic [GAIN_W-1:0] gain
);
  logic [GAIN_W-1:0] tgt_q, tgt_d, out_q, out_d, tgt_step, manual_c;
  logic              upd;
  int                t_i;

  always_comb begin
    t_i = int'(tgt_q);
    if (atk)      t_i = t_i - ALC_STEP;
    else if (rel) t_i = t_i + ALC_STEP;
    tgt_step = GAIN_W'(clamp_int(t_i, GAIN_FLOOR, GAIN_CEIL));
    manual_c = GAIN_W'(clamp_int(int'(manual), GAIN_FLOOR, GAIN_CEIL));
    upd   = !en || vld;
    tgt_d = tgt_q;
    out_d = out_q;
    if (!en) begin
      tgt_d = manual_c;
      out_d = manual_c;
    end else if (vld) begin
      tgt_d = tgt_step;
      if (instant)               out_d = tgt_step;
      else if (out_q < tgt_step) out_d = out_q + GAIN_W'(1);
      else if (out_q > tgt_step) out_d = out_q - GAIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= GAIN_W'(GAIN_RESET);
      out_q <= GAIN_W'(GAIN_RESET);
    end else if (upd) begin
      tgt_q <= tgt_d;
      out_q <= out_d;
    end
  end

  assign gain = out_q;
endmodule

// File: rtl/alc_channel.sv
module alc_channel
  import alc_pkg::*;
#(
  parameter int SMP_W      = 24,
  parameter int GAIN_W     = 6,
  parameter int GAIN_FLOOR = 0,
  parameter int GAIN_CEIL  = 40,
  parameter int GAIN_RESET = 24,
  parameter int BASE_IVL   = 4,
  parameter int ALC_STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              instant,
  input  logic [SMP_W-1:0]  thr_max,
  input  logic [SMP_W-1:0]  thr_min,
  input  logic [RATE_W-1:0] atk_rate,
  input  logic [RATE_W-1:0] rel_rate,
  input  logic [GAIN_W-1:0] manual,
  input  logic              vld,
  input  logic [SMP_W-1:0]  smp,
  output logic [GAIN_W-1:0] gain
);
  logic [SMP_W-1:0] mag, pk_atk, pk_rel;
  logic             fire_atk, fire_rel, do_atk, do_rel;

  assign mag = smp[SMP_W-1] ? (~smp + SMP_W'(1)) : smp;

  alc_window #(.SMP_W(SMP_W), .BASE_IVL(BASE_IVL)) u_win_atk (
    .clk(clk), .rst_n(rst_n), .clr(!en), .vld(vld), .mag(mag),
    .rate(atk_rate), .fire(fire_atk), .peak(pk_atk)
  );

  alc_window #(.SMP_W(SMP_W), .BASE_IVL(BASE_IVL)) u_win_rel (
    .clk(clk), .rst_n(rst_n), .clr(!en), .vld(vld), .mag(mag),
    .rate(rel_rate), .fire(fire_rel), .peak(pk_rel)
  );

  assign do_atk = fire_atk && (pk_atk >= thr_max);
  assign do_rel = fire_rel && (pk_rel < thr_min) && !do_atk;

  alc_gain_track #(
    .GAIN_W(GAIN_W), .GAIN_FLOOR(GAIN_FLOOR), .GAIN_CEIL(GAIN_CEIL),
    .GAIN_RESET(GAIN_RESET), .ALC_STEP(ALC_STEP)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .en(en), .vld(vld), .atk(do_atk), .rel(do_rel),
    .instant(instant), .manual(manual), .gain(gain)
  );
endmodule

// File: rtl/alc_ctrl.sv
module alc_ctrl
  import alc_pkg::*;
#(
  parameter int SMP_W      = 24,
  parameter int GAIN_W     = 6,
  parameter int GAIN_FLOOR = 0,
  parameter int GAIN_CEIL  = 40,
  parameter int GAIN_RESET = 24,
  parameter int BASE_IVL   = 4,
  parameter int ALC_STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en_a,
  input  logic              cfg_en_b,
  input  logic              cfg_single,
  input  logic              cfg_instant,
  input  logic [2:0]        cfg_max_lvl,
  input  logic [2:0]        cfg_min_lvl,
  input  logic [5:0]        cfg_atk_rate,
  input  logic [5:0]        cfg_rel_rate,
  input  logic [GAIN_W-1:0] cfg_manual_a,
  input  logic [GAIN_W-1:0] cfg_manual_b,
  input  logic              smp_vld_a,
  input  logic [SMP_W-1:0]  smp_a,
  input  logic              smp_vld_b,
  input  logic [SMP_W-1:0]  smp_b,
  output logic [GAIN_W-1:0] gain_a,
  output logic [GAIN_W-1:0] gain_b
);
  localparam int CH_N = 2;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [SMP_W-1:0]  thr_max, thr_min;
  logic              ch_en  [CH_N];
  logic              ch_vld [CH_N];
  logic [SMP_W-1:0]  ch_smp [CH_N];
  logic [GAIN_W-1:0] ch_man [CH_N];
  logic [GAIN_W-1:0] ch_gain[CH_N];

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  alc_thresh_dec #(.SMP_W(SMP_W)) u_thr_max (.lvl(cfg_max_lvl), .thr(thr_max));
  alc_thresh_dec #(.SMP_W(SMP_W)) u_thr_min (.lvl(cfg_min_lvl), .thr(thr_min));

  assign ch_en[0]  = cfg_en_a;
  assign ch_en[1]  = cfg_single ? cfg_en_a : cfg_en_b;
  assign ch_vld[0] = smp_vld_a;
  assign ch_vld[1] = smp_vld_b;
  assign ch_smp[0] = smp_a;
  assign ch_smp[1] = smp_b;
  assign ch_man[0] = cfg_manual_a;
  assign ch_man[1] = cfg_manual_b;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    alc_channel #(
      .SMP_W(SMP_W), .GAIN_W(GAIN_W), .GAIN_FLOOR(GAIN_FLOOR),
      .GAIN_CEIL(GAIN_CEIL), .GAIN_RESET(GAIN_RESET),
      .BASE_IVL(BASE_IVL), .ALC_STEP(ALC_STEP)
    ) u_ch (
      .clk(clk), .rst_n(rst_sync_n), .en(ch_en[c]), .instant(cfg_instant),
      .thr_max(thr_max), .thr_min(thr_min),
      .atk_rate(cfg_atk_rate), .rel_rate(cfg_rel_rate),
      .manual(ch_man[c]), .vld(ch_vld[c]), .smp(ch_smp[c]), .gain(ch_gain[c])
    );
  end

  assign gain_a = ch_gain[0];
  assign gain_b = ch_gain[1];
endmodule

// File: rtl/alc_ctrl_chk.sv
module alc_ctrl_chk #(
  parameter int GAIN_W     = 6,
  parameter int GAIN_FLOOR = 0,
  parameter int GAIN_CEIL  = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en_a,
  input logic              cfg_en_b,
  input logic              cfg_single,
  input logic              cfg_instant,
  input logic              smp_vld_a,
  input logic              smp_vld_b,
  input logic [GAIN_W-1:0] cfg_manual_a,
  input logic [GAIN_W-1:0] cfg_manual_b,
  input logic [GAIN_W-1:0] gain_a,
  input logic [GAIN_W-1:0] gain_b
);
  logic en_b_eff;
  assign en_b_eff = cfg_single ? cfg_en_a : cfg_en_b;

  function automatic int clampc(logic [GAIN_W-1:0] v);
    if (int'(v) < GAIN_FLOOR) return GAIN_FLOOR;
    if (int'(v) > GAIN_CEIL)  return GAIN_CEIL;
    return int'(v);
  endfunction

  assert_gain_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gain_a) >= GAIN_FLOOR && int'(gain_a) <= GAIN_CEIL &&
    int'(gain_b) >= GAIN_FLOOR && int'(gain_b) <= GAIN_CEIL);

  assert_manual_hold_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en_a |=> int'(gain_a) == clampc($past(cfg_manual_a)));

  assert_single_mode_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_single && !cfg_en_a) |=> int'(gain_b) == clampc($past(cfg_manual_b)));

  assert_ramp_one_code_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en_a && !cfg_instant) |=>
      (int'(gain_a) - int'($past(gain_a)) <= 1) && (int'($past(gain_a)) - int'(gain_a) <= 1));

  assert_idle_stable_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en_a && !smp_vld_a) |=> $stable(gain_a));

  assert_idle_stable_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_b_eff && !smp_vld_b) |=> $stable(gain_b));
endmodule

bind alc_ctrl alc_ctrl_chk #(
  .GAIN_W(GAIN_W), .GAIN_FLOOR(GAIN_FLOOR), .GAIN_CEIL(GAIN_CEIL)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cfg_en_a(cfg_en_a), .cfg_en_b(cfg_en_b),
  .cfg_single(cfg_single), .cfg_instant(cfg_instant),
  .smp_vld_a(smp_vld_a), .smp_vld_b(smp_vld_b),
  .cfg_manual_a(cfg_manual_a), .cfg_manual_b(cfg_manual_b),
  .gain_a(gain_a), .gain_b(gain_b)
);

// File: tb/alc_ctrl_tb.sv
module alc_ctrl_tb;
  localparam int SW = 8;
  localparam int GW = 5;
  localparam int FLR = 2;
  localparam int CEI = 20;
  localparam int RSTV = 9;
  localparam int STEP = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_en_a, cfg_en_b, cfg_single, cfg_instant;
  logic [2:0] cfg_max_lvl, cfg_min_lvl;
  logic [5:0] cfg_atk_rate, cfg_rel_rate;
  logic [GW-1:0] cfg_manual_a, cfg_manual_b;
  logic smp_vld_a, smp_vld_b;
  logic [SW-1:0] smp_a, smp_b;
  logic [GW-1:0] gain_a, gain_b;

  int checks = 0;
  int errors = 0;
  int g;

  always #5 clk = ~clk;

  alc_ctrl #(.SMP_W(SW), .GAIN_W(GW), .GAIN_FLOOR(FLR), .GAIN_CEIL(CEI),
             .GAIN_RESET(RSTV), .BASE_IVL(1), .ALC_STEP(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en_a(cfg_en_a), .cfg_en_b(cfg_en_b),
    .cfg_single(cfg_single), .cfg_instant(cfg_instant),
    .cfg_max_lvl(cfg_max_lvl), .cfg_min_lvl(cfg_min_lvl),
    .cfg_atk_rate(cfg_atk_rate), .cfg_rel_rate(cfg_rel_rate),
    .cfg_manual_a(cfg_manual_a), .cfg_manual_b(cfg_manual_b),
    .smp_vld_a(smp_vld_a), .smp_a(smp_a), .smp_vld_b(smp_vld_b), .smp_b(smp_b),
    .gain_a(gain_a), .gain_b(gain_b)
  );

  function automatic int thr(int k);
    int t;
    t = (1 << (SW - 1)) >> (k / 2);
    if ((k % 2) == 1) t = (t * 181) >> 8;
    return t;
  endfunction

  function automatic int clampv(int v);
    if (v < FLR) return FLR;
    if (v > CEI) return CEI;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_a(int v);
    @(negedge clk);
    smp_vld_a = 1'b1;
    smp_a = SW'(v);
    @(negedge clk);
    smp_vld_a = 1'b0;
  endtask

  task automatic send_b(int v);
    @(negedge clk);
    smp_vld_b = 1'b1;
    smp_b = SW'(v);
    @(negedge clk);
    smp_vld_b = 1'b0;
  endtask

  task automatic restart_a(int m);
    @(negedge clk);
    cfg_en_a = 1'b0;
    cfg_manual_a = GW'(m);
    @(negedge clk);
    @(negedge clk);
    cfg_en_a = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_en_a = 0; cfg_en_b = 0; cfg_single = 0; cfg_instant = 1;
    cfg_max_lvl = 0; cfg_min_lvl = 0; cfg_atk_rate = 0; cfg_rel_rate = 0;
    cfg_manual_a = 5'd14; cfg_manual_b = 5'd14;
    smp_vld_a = 0; smp_vld_b = 0; smp_a = 0; smp_b = 0;
    repeat (3) @(negedge clk);
    check("R1 gain_a in reset", int'(gain_a), RSTV);
    check("R1 gain_b in reset", int'(gain_b), RSTV);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: manual code, clamped, while disabled
    for (int m = 0; m < 32; m++) begin
      cfg_manual_a = GW'(m);
      @(negedge clk);
      check("R2 manual clamp", int'(gain_a), clampv(m));
    end
    cfg_manual_a = 5'd7;
    send_a(-128);
    check("R2 samples ignored while disabled", int'(gain_a), 7);

    // R3 sweep: every level pairing, threshold edges, both signs
    cfg_instant = 1; cfg_atk_rate = 0; cfg_rel_rate = 0;
    restart_a(11);
    g = 11;
    for (int kx = 0; kx < 8; kx++) begin
      for (int kn = 0; kn < 8; kn++) begin
        cfg_max_lvl = 3'(kx);
        cfg_min_lvl = 3'(kn);
        for (int i = 0; i < 4; i++) begin
          for (int s = 0; s < 2; s++) begin
            int m, v, a;
            m = (i == 0) ? thr(kx) : (i == 1) ? thr(kx) - 1 : (i == 2) ? thr(kn) : thr(kn) - 1;
            v = (s == 1) ? -m : m;
            if (v > 127) v = 127;
            a = (v < 0) ? -v : v;
            send_a(v);
            if (a >= thr(kx))     g = clampv(g - STEP);
            else if (a < thr(kn)) g = clampv(g + STEP);
            check("R3 level decision", int'(gain_a), g);
          end
        end
      end
    end

    // R4: attack window length for every rate code
    cfg_max_lvl = 1; cfg_min_lvl = 7; cfg_rel_rate = 63;
    for (int n = 0; n < 64; n++) begin
      cfg_atk_rate = 6'(n);
      restart_a(14);
      for (int k = 0; k < n; k++) send_a(100);
      check("R4 before attack window end", int'(gain_a), 14);
      send_a(100);
      check("R4 at attack window end", int'(gain_a), 12);
    end

    // R5: release window length for every rate code
    cfg_max_lvl = 0; cfg_min_lvl = 0; cfg_atk_rate = 0;
    for (int n = 0; n < 64; n++) begin
      cfg_rel_rate = 6'(n);
      restart_a(8);
      for (int k = 0; k < n; k++) send_a(0);
      check("R5 before release window end", int'(gain_a), 8);
      send_a(0);
      check("R5 at release window end", int'(gain_a), 10);
    end

    // R8: instant step
    cfg_max_lvl = 1; cfg_min_lvl = 7; cfg_atk_rate = 0; cfg_rel_rate = 63;
    restart_a(14);
    send_a(100);
    check("R8 instant step", int'(gain_a), 12);

    // R7: ramp one code per sample
    cfg_instant = 0;
    restart_a(14);
    send_a(100);
    check("R7 ramp first code", int'(gain_a), 13);
    repeat (3) @(negedge clk);
    check("R7 no move without sample", int'(gain_a), 13);
    send_a(50);
    check("R7 ramp second code", int'(gain_a), 12);
    send_a(50);
    check("R7 rests at target", int'(gain_a), 12);
    cfg_instant = 1;

    // R11: peak hold over window, cleared after decision
    cfg_atk_rate = 3;
    restart_a(14);
    send_a(100); send_a(50); send_a(50);
    check("R11 mid window", int'(gain_a), 14);
    send_a(50);
    check("R11 early peak counted", int'(gain_a), 12);
    for (int k = 0; k < 4; k++) send_a(50);
    check("R11 peak cleared", int'(gain_a), 12);

    // R6: limits
    cfg_atk_rate = 0;
    restart_a(3);
    send_a(100);
    check("R6 floor clamp", int'(gain_a), FLR);
    send_a(-100);
    check("R6 stays at floor", int'(gain_a), FLR);
    cfg_max_lvl = 0; cfg_min_lvl = 0; cfg_rel_rate = 0;
    restart_a(19);
    send_a(0);
    check("R6 ceiling clamp", int'(gain_a), CEI);
    send_a(0);
    check("R6 stays at ceiling", int'(gain_a), CEI);

    // R10: channel independence
    cfg_max_lvl = 1; cfg_min_lvl = 7; cfg_rel_rate = 63;
    restart_a(14);
    cfg_manual_b = 14;
    cfg_en_b = 1;
    @(negedge clk);
    send_b(100);
    check("R10 B moves", int'(gain_b), 12);
    check("R10 A untouched", int'(gain_a), 14);
    send_a(100);
    check("R10 B untouched by A", int'(gain_b), 12);

    // R9: single mode
    cfg_en_b = 0; cfg_manual_b = 14; cfg_single = 1;
    @(negedge clk);
    cfg_en_a = 0;
    @(negedge clk);
    cfg_en_a = 1;
    @(negedge clk);
    send_b(100);
    check("R9 B enabled by A", int'(gain_b), 12);
    cfg_en_a = 0; cfg_en_b = 1; cfg_manual_b = 5;
    @(negedge clk);
    send_b(100);
    check("R9 B held by A disable", int'(gain_b), 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule